// File: doc/BRIEF.md
# Write-Through Direct-Mapped Cache Controller

This block is a small direct-mapped cache that sits between a CPU bus and a slower byte-wide main memory. It has sixteen lines of one byte each. Every line stores a four-bit tag and a valid flag. The CPU address splits into a line index and a tag. A combinational compare of the stored tag and the valid flag gives the hit signal.

A four-state controller sequences each access and then waits in idle for the next one.

- **Read hit:** served from the cache in a single cycle.
- **Read miss:** starts a main-memory read and passes the returned byte to the CPU. The byte and its tag are loaded into the indexed line.
- **Write (hit or miss):** always writes through to main memory. It also loads both the byte and the tag into the cache, so a write miss allocates the line just as a write hit does.

For memory accesses, the CPU acknowledge follows the memory ready signal directly.

Top module: `wt_dm_cache`

## Requirements
- R1: The low 4 address bits select one of 16 lines. The high 4 bits are the tag. Addresses that share the low nibble but differ in the high nibble use the same line.
- R2: After reset the state code is 3'b000 (idle) and every line is invalid, so `hit` is 0 for every address. In idle the outputs are: `cpu_ack`=0, `cache_oe`=0, `cache_we_n`=1, `mem_oe`=0, `mem_we_n`=1, `mem_start`=0.
- R3: From idle, the next state is chosen as follows:
  - a write request (with or without a read) moves to 3'b001;
  - a read that hits moves to 3'b010;
  - a read that misses moves to 3'b100;
  - with no request the controller stays in 3'b000.
- R4: In the write state (3'b001) the outputs are `cache_we_n`=0, `mem_we_n`=0, `mem_start`=1, `mem_oe`=0, `cache_oe`=0 and `cpu_ack`=`mem_ready`. The state holds until `mem_ready` and then returns to idle.
- R5: A write stores the byte in main memory and stores both the byte and the tag in the indexed line, whether or not it hit. A later read of the same address hits and returns that byte.
- R6: The read-hit state (3'b010) lasts exactly one cycle. Its outputs are `cpu_ack`=1, `cache_oe`=1, `cache_we_n`=1 and `mem_start`=0. `cpu_rdata` carries the cached byte.
- R7: In the read-miss state (3'b100) the outputs are `mem_start`=1, `mem_oe`=1, `mem_we_n`=1, `cache_we_n`=0 and `cpu_ack`=`mem_ready`. `cpu_rdata` carries `mem_rdata`. The state holds until `mem_ready`. The line is then filled, so a repeat read of the same address hits.
- R8: Filling or writing a line evicts any other address that shares its index. A later read of the evicted address misses and returns the main-memory byte.
- R9: `hit` is 1 only when the indexed line is valid and its stored tag equals the address tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 8 | CPU byte address |
| cpu_rd | input | 1 | Read request |
| cpu_wr | input | 1 | Write request |
| cpu_wdata | input | 8 | Write data from the CPU |
| cpu_rdata | output | 8 | Read data to the CPU |
| cpu_ack | output | 1 | Access complete |
| hit | output | 1 | Indexed line is valid and its tag matches |
| cache_oe | output | 1 | Cache drives the CPU read bus |
| cache_we_n | output | 1 | Active-low cache data/tag write |
| mem_start | output | 1 | Main-memory access in progress |
| mem_oe | output | 1 | Memory drives the CPU read bus |
| mem_we_n | output | 1 | Active-low memory write select |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| mem_ready | input | 1 | Memory access done |
| ctl_state | output | 3 | Controller state code |

## Verification
The assertions assume the following about the CPU and the memory:
- The CPU holds `cpu_addr` and its request steady until it sees `cpu_ack`, then drops the request before the next edge.
- The memory raises `mem_ready` only while `mem_start` is high, for a single cycle.

The bench drives each request at a falling edge. It keeps the address after the acknowledge and lowers the request at the falling edge where the acknowledge is seen. Its behavioural memory counts four cycles of `mem_start` before it pulses ready once.

// File: rtl/wt_dm_cache.sv
module wt_dm_cache #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ack,
  output logic              hit,
  output logic              cache_oe,
  output logic              cache_we_n,
  output logic              mem_start,
  output logic              mem_oe,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic [2:0]        ctl_state
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int DEPTH = 1 << IDX_W;

  typedef enum logic [2:0] {
    S_IDLE = 3'b000,
    S_WR   = 3'b001,
    S_RH   = 3'b010,
    S_RM   = 3'b100
  } state_t;

  state_t state, state_nx;

  logic [DATA_W-1:0] data_arr [DEPTH];
  logic [TAG_W-1:0]  tag_arr  [DEPTH];
  logic [DEPTH-1:0]  valid;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic in_wr, in_rh, in_rm;

  assign idx = cpu_addr[IDX_W-1:0];
  assign tag = cpu_addr[ADDR_W-1:IDX_W];
  assign hit = valid[idx] && (tag_arr[idx] == tag);

  assign in_wr = (state == S_WR);
  assign in_rh = (state == S_RH);
  assign in_rm = (state == S_RM);

  assign cpu_ack    = in_rh | ((in_wr | in_rm) & mem_ready);
  assign cache_oe   = in_rh;
  assign cache_we_n = ~(in_wr | in_rm);
  assign mem_start  = in_wr | in_rm;
  assign mem_oe     = in_rm;
  assign mem_we_n   = ~in_wr;
  assign mem_addr   = cpu_addr;
  assign mem_wdata  = cpu_wdata;
  assign ctl_state  = state;

  assign cpu_rdata = cache_oe ? data_arr[idx] : (mem_oe ? mem_rdata : '0);

  always_comb begin
    state_nx = state;
    case (state)
      S_IDLE: begin
        if (cpu_wr)      state_nx = S_WR;
        else if (cpu_rd) state_nx = hit ? S_RH : S_RM;
      end
      S_WR:    if (mem_ready) state_nx = S_IDLE;
      S_RH:    state_nx = S_IDLE;
      S_RM:    if (mem_ready) state_nx = S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= state_nx;
  end

  always_ff @(posedge clk) begin
    if (!cache_we_n) begin
      data_arr[idx] <= in_rm ? mem_rdata : cpu_wdata;
      tag_arr[idx]  <= tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           valid      <= '0;
    else if (!cache_we_n) valid[idx] <= 1'b1;
  end

  assert_rh_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_rh |=> (state == S_IDLE));

  assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wr && !mem_ready) |=> in_wr);

  assert_rm_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rm && !mem_ready) |=> in_rm);

  assert_fill_hits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rm && mem_ready) |=> (!$stable(cpu_addr) || hit));

  assert_write_allocates_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wr && mem_ready) |=> (!$stable(cpu_addr) || hit));

  assert_idle_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && cpu_rd && !cpu_wr && !hit) |=> in_rm);

  assert_bus_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cache_oe && mem_oe));
endmodule

// File: tb/tb_wt_dm_cache.sv
module tb_wt_dm_cache;
  localparam int LAT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cpu_addr = '0;
  logic cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic cpu_ack, hit, cache_oe, cache_we_n, mem_start, mem_oe, mem_we_n;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic mem_ready = 1'b0;
  logic [2:0] ctl_state;

  always #2 clk = ~clk;

  wt_dm_cache dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack), .hit(hit),
    .cache_oe(cache_oe), .cache_we_n(cache_we_n), .mem_start(mem_start), .mem_oe(mem_oe),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .ctl_state(ctl_state)
  );

  logic [7:0] mem [256];
  int cnt = 0;
  assign mem_rdata = mem[mem_addr];

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h3C;

  always @(posedge clk) begin
    if (mem_start && !mem_ready) begin
      if (cnt == LAT - 1) begin
        mem_ready <= 1'b1;
        cnt <= 0;
        if (!mem_we_n) mem[mem_addr] <= mem_wdata;
      end else cnt <= cnt + 1;
    end else mem_ready <= 1'b0;
  end

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // vector: {op(4), addr(8), data(8), state(4)}
  localparam logic [23:0] VEC [11] = '{
    24'h1_00_11_1, 24'h1_10_22_1, 24'h1_20_33_1, 24'h1_30_44_1,
    24'h0_30_44_2, 24'h0_20_33_4, 24'h0_20_33_2, 24'h0_10_22_4,
    24'h0_10_22_2, 24'h0_00_11_4, 24'h0_00_11_2
  };

  task automatic access(input bit w, input bit r, input logic [7:0] a, input logic [7:0] d,
                        input logic [2:0] exp_st, input logic [7:0] exp_d, input string req);
    int waits;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = w; cpu_rd = r;
    #0.5;
    if (!w) chk(hit == (exp_st == 3'b010), {req, " R9 hit"}, int'(hit), int'(exp_st == 3'b010));
    @(negedge clk);
    chk(ctl_state == exp_st, {req, " R3 state"}, int'(ctl_state), int'(exp_st));
    case (exp_st)
      3'b001: chk(!cache_we_n && !mem_we_n && mem_start && !mem_oe && !cache_oe && !cpu_ack,
                  {req, " R4 write outputs"}, int'({cache_we_n, mem_we_n, mem_start, mem_oe, cpu_ack}), 5'b00100);
      3'b010: chk(cpu_ack && cache_oe && cache_we_n && !mem_start,
                  {req, " R6 hit outputs"}, int'({cpu_ack, cache_oe, cache_we_n, mem_start}), 4'b1110);
      3'b100: chk(mem_start && mem_oe && mem_we_n && !cache_we_n && !cpu_ack,
                  {req, " R7 miss outputs"}, int'({mem_start, mem_oe, mem_we_n, cache_we_n, cpu_ack}), 5'b11100);
      default: ;
    endcase
    waits = 0;
    while (!cpu_ack && waits < 50) begin @(negedge clk); waits++; end
    if (exp_st == 3'b010) chk(waits == 0, {req, " R6 one cycle"}, waits, 0);
    else chk(waits == LAT, {req, " R4/R7 ack on ready"}, waits, LAT);
    if (!w) chk(cpu_rdata == exp_d, {req, " R5/R7 read data"}, int'(cpu_rdata), int'(exp_d));
    cpu_wr = 0; cpu_rd = 0;
    @(negedge clk);
    chk(ctl_state == 3'b000, {req, " R4/R6/R7 back to idle"}, int'(ctl_state), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctl_state == 3'b000 && !hit, "R2 reset state", int'({ctl_state, hit}), 0);
    chk(!cpu_ack && !cache_oe && cache_we_n && !mem_oe && mem_we_n && !mem_start,
        "R2 idle outputs", int'({cpu_ack, cache_oe, cache_we_n, mem_oe, mem_we_n, mem_start}), 6'b001010);
    repeat (3) @(negedge clk);
    chk(ctl_state == 3'b000 && !mem_start, "R3 no request stays idle", int'(ctl_state), 0);

    for (int i = 0; i < 11; i++) begin
      logic [23:0] v;
      v = VEC[i];
      access(v[20], !v[20], v[19:12], v[11:4], v[2:0], v[11:4], "R8 table");
    end
    chk(mem[8'h30] == 8'h44, "R5 write-through to memory", int'(mem[8'h30]), 8'h44);

    access(1, 1, 8'h5A, 8'hA5, 3'b001, 8'h00, "R3 write wins over read");
    access(0, 1, 8'h5A, 8'h00, 3'b010, 8'hA5, "R5 write miss allocates");
    access(0, 1, 8'h4A, 8'h00, 3'b100, 8'h4A ^ 8'h3C, "R1 same index other tag");
    access(0, 1, 8'h5A, 8'h00, 3'b100, 8'hA5, "R8 evicted line misses");
    access(0, 1, 8'h5B, 8'h00, 3'b100, 8'h5B ^ 8'h3C, "R1 neighbour index independent");
    access(0, 1, 8'h5A, 8'h00, 3'b010, 8'hA5, "R1 refilled line hits");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R3 actual=%0h expected=%0h", ctl_state, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule